// File: doc/BRIEF.md
# I2C Status Flag and Interrupt Controller

This block keeps the event and error status flags of an I2C peripheral and derives the interrupt request lines from them. The bus engine sends one-cycle set pulses, one per flag. The register decoder sends one-cycle access strobes: status read, status write, data read, data write and control write. Software clears a flag either with a two-step access order or by writing zero to the flag's bit. A bit that pairs with a flag that does not use write-zero clearing is ignored. Three enable inputs gate the interrupt lines: event, buffer and error. A peripheral enable input resets all flag state while it is low.

Five event flags clear through a two-access order. Each of them has its own small state machine with two states, `SEQ_IDLE` and `SEQ_ARMED`. The machine moves from `SEQ_IDLE` to `SEQ_ARMED` on a status read while its flag is set. It moves from `SEQ_ARMED` back to `SEQ_IDLE` in any of these cases:
- the flag's required second access occurs, which also clears the flag;
- any other non-status-read access occurs;
- a status read occurs while the flag is clear;
- the peripheral is disabled.

A status read while the flag is set keeps or re-enters `SEQ_ARMED`.

Flag positions in `set_i` and `flags_o`:

| Bit | Flag |
|---|---|
| 0 | start sent |
| 1 | address |
| 2 | 10-bit header |
| 3 | stop received |
| 4 | byte finished |
| 5 | wakeup |
| 6 | receive not empty |
| 7 | transmit empty |
| 8 | bus error |
| 9 | arbitration lost |
| 10 | acknowledge failure |
| 11 | overrun/underrun |

Top module: `i2c_irq_flags`

## Requirements
- R1: `irq_evt_o` is high exactly when `evt_ie_i` is high and at least one of the following holds: any of flags 0..5 is set, or `buf_ie_i` is high and flag 6 or flag 7 is set.
- R2: Flags 6 and 7 raise `irq_evt_o` only while both `evt_ie_i` and `buf_ie_i` are high.
- R3: `irq_err_o` is high exactly when `err_ie_i` is high and any of flags 8..11 is set.
- R4: `irq_o` is the OR of `irq_evt_o` and `irq_err_o`.
- R5: Flag 2 (10-bit header) clears only on a data write that directly follows a status read made while the flag was set. No other register access may come between the two.
- R6: The other two-step flags use these second accesses: flag 0 a data write, flag 1 a data read, flag 3 a control write, flag 4 a data read or a data write. Each second access takes effect only directly after a status read made while that flag was set.
- R7: Any access other than a status read, and other than the flag's own second access, disarms a pending clear order. A new status read re-arms it.
- R8: A status write clears flag 5 through `sts_wdata_i[0]`, flag 8 through bit 1, flag 9 through bit 2, flag 10 through bit 3 and flag 11 through bit 4, when that bit is 0. A bit written as 1 leaves its flag unchanged.
- R9: A set pulse in the same cycle as a clearing access wins, and the flag stays set.
- R10: Flag 6 clears on a data read and flag 7 clears on a data write.
- R11: A start-sent pulse (bit 0) sets `master_o`. An arbitration-lost pulse (bit 9) clears `master_o`, and it wins if both pulses arrive in the same cycle.
- R12: While `en_i` is low, every flag and `master_o` are 0 after the next edge, set pulses are ignored, and every armed clear order is dropped.
- R13: `halt_wake_o` is high exactly when `evt_ie_i` is high and flag 5 is set. No other flag drives it.
- R14: After reset, all flags, `master_o` and all interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Peripheral enable |
| evt_ie_i | input | 1 | Event interrupt enable |
| buf_ie_i | input | 1 | Buffer interrupt enable |
| err_ie_i | input | 1 | Error interrupt enable |
| set_i | input | 12 | Flag set pulses from the bus engine |
| sts_rd_i | input | 1 | Status register read strobe |
| sts_wr_i | input | 1 | Status register write strobe |
| sts_wdata_i | input | 5 | Write-zero clear data for flags 5, 8, 9, 10, 11 |
| dat_rd_i | input | 1 | Data register read strobe |
| dat_wr_i | input | 1 | Data register write strobe |
| ctl_wr_i | input | 1 | Control register write strobe |
| flags_o | output | 12 | Flag state |
| master_o | output | 1 | Master-mode status |
| irq_evt_o | output | 1 | Event interrupt |
| irq_err_o | output | 1 | Error interrupt |
| irq_o | output | 1 | Combined interrupt |
| halt_wake_o | output | 1 | Wakeup request usable from halt |

## Verification
Directed sequences try each two-step order in three forms: clean, broken by a foreign access, and repeated after a fresh status read. This separates a flag that clears on the right order from one that clears on any second access or that forgets its arm. Same-cycle set and clear, a disable that lands while a flag is armed, and the enable combinations on the buffer flags isolate the priority, disarm and gating rules. A long seeded random run sends mixed pulses, strobes and enable changes through a bench-side model built from the requirements. It catches interactions that no directed case reaches.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

    localparam int unsigned NFLAG   = 12;
    localparam int unsigned NSEQ    = 5;
    localparam int unsigned NW0C    = 5;

    localparam int unsigned F_START = 0;
    localparam int unsigned F_ADDR  = 1;
    localparam int unsigned F_HDR10 = 2;
    localparam int unsigned F_STOP  = 3;
    localparam int unsigned F_BYTE  = 4;
    localparam int unsigned F_WAKE  = 5;
    localparam int unsigned F_RXNE  = 6;
    localparam int unsigned F_TXE   = 7;
    localparam int unsigned F_BUS   = 8;
    localparam int unsigned F_ARB   = 9;
    localparam int unsigned F_ACK   = 10;
    localparam int unsigned F_OVR   = 11;

    typedef enum logic [1:0] {
        ACC_DWR  = 2'd0,
        ACC_DRD  = 2'd1,
        ACC_DANY = 2'd2,
        ACC_CWR  = 2'd3
    } second_e;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_ARMED = 1'b1
    } seq_state_e;

    function automatic second_e seq_kind(input int unsigned idx);
        second_e k;
        unique case (idx)
            F_START: k = ACC_DWR;
            F_ADDR:  k = ACC_DRD;
            F_HDR10: k = ACC_DWR;
            F_STOP:  k = ACC_CWR;
            default: k = ACC_DANY;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/i2c_clr_seq.sv
module i2c_clr_seq
    import i2c_irq_pkg::*;
#(
    parameter second_e SECOND = ACC_DWR
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic set,
    input  logic sts_rd,
    input  logic sts_wr,
    input  logic dat_rd,
    input  logic dat_wr,
    input  logic ctl_wr,
    output logic flag_o,
    output logic armed_o
);

    seq_state_e state_q, state_d;
    logic       flag_q, flag_d;
    logic       sec_hit;
    logic       other_acc;

    always_comb begin
        unique case (SECOND)
            ACC_DWR:  sec_hit = dat_wr;
            ACC_DRD:  sec_hit = dat_rd;
            ACC_DANY: sec_hit = dat_rd | dat_wr;
            ACC_CWR:  sec_hit = ctl_wr;
            default:  sec_hit = 1'b0;
        endcase
    end

    assign other_acc = sts_wr | dat_rd | dat_wr | ctl_wr;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = SEQ_IDLE;
        end else if (sts_rd) begin
            state_d = flag_q ? SEQ_ARMED : SEQ_IDLE;
        end else begin
            unique case (state_q)
                SEQ_IDLE:  state_d = SEQ_IDLE;
                SEQ_ARMED: state_d = other_acc ? SEQ_IDLE : SEQ_ARMED;
                default:   state_d = SEQ_IDLE;
            endcase
        end
    end

    // Output flag
    always_comb begin
        flag_d = flag_q;
        if (!en) begin
            flag_d = 1'b0;
        end else if (set) begin
            flag_d = 1'b1;
        end else if ((state_q == SEQ_ARMED) && sec_hit) begin
            flag_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag_o  = flag_q;
    assign armed_o = (state_q == SEQ_ARMED);

endmodule

// File: rtl/i2c_w0c_bank.sv
module i2c_w0c_bank #(
    parameter int unsigned W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] set,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] flags_o
);

    for (genvar gi = 0; gi < W; gi++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else if (!en) begin
                bit_q <= 1'b0;
            end else if (set[gi]) begin
                bit_q <= 1'b1;
            end else if (wr && !wdata[gi]) begin
                bit_q <= 1'b0;
            end
        end
        assign flags_o[gi] = bit_q;
    end

endmodule

// File: rtl/i2c_irq_merge.sv
module i2c_irq_merge #(
    parameter int unsigned NEVT = 6,
    parameter int unsigned NBUF = 2,
    parameter int unsigned NERR = 4,
    parameter int unsigned WAKE_IDX = 5
) (
    input  logic [NEVT-1:0] evt_flags,
    input  logic [NBUF-1:0] buf_flags,
    input  logic [NERR-1:0] err_flags,
    input  logic            evt_ie,
    input  logic            buf_ie,
    input  logic            err_ie,
    output logic            irq_evt_o,
    output logic            irq_err_o,
    output logic            irq_o,
    output logic            wake_o
);

    logic evt_any, buf_any, err_any;

    assign evt_any   = |evt_flags;
    assign buf_any   = buf_ie & (|buf_flags);
    assign err_any   = |err_flags;

    assign irq_evt_o = evt_ie & (evt_any | buf_any);
    assign irq_err_o = err_ie & err_any;
    assign irq_o     = irq_evt_o | irq_err_o;
    assign wake_o    = evt_ie & evt_flags[WAKE_IDX];

endmodule

// File: rtl/i2c_irq_flags.sv
module i2c_irq_flags
    import i2c_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             evt_ie_i,
    input  logic             buf_ie_i,
    input  logic             err_ie_i,
    input  logic [NFLAG-1:0] set_i,
    input  logic             sts_rd_i,
    input  logic             sts_wr_i,
    input  logic [NW0C-1:0]  sts_wdata_i,
    input  logic             dat_rd_i,
    input  logic             dat_wr_i,
    input  logic             ctl_wr_i,
    output logic [NFLAG-1:0] flags_o,
    output logic             master_o,
    output logic             irq_evt_o,
    output logic             irq_err_o,
    output logic             irq_o,
    output logic             halt_wake_o
);

    logic [NSEQ-1:0] seq_flags;
    logic [NSEQ-1:0] seq_armed;
    logic [NW0C-1:0] w0c_set;
    logic [NW0C-1:0] w0c_flags;
    logic            rxne_q, txe_q, master_q;

    // Two-access clear flags occupy bits 0..NSEQ-1
    for (genvar gi = 0; gi < NSEQ; gi++) begin : g_seq
        i2c_clr_seq #(
            .SECOND (seq_kind(gi))
        ) u_seq (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (en_i),
            .set     (set_i[gi]),
            .sts_rd  (sts_rd_i),
            .sts_wr  (sts_wr_i),
            .dat_rd  (dat_rd_i),
            .dat_wr  (dat_wr_i),
            .ctl_wr  (ctl_wr_i),
            .flag_o  (seq_flags[gi]),
            .armed_o (seq_armed[gi])
        );
    end

    // Write-zero clear flags: wake and the four errors
    assign w0c_set = {set_i[F_OVR], set_i[F_ACK], set_i[F_ARB], set_i[F_BUS], set_i[F_WAKE]};

    i2c_w0c_bank #(
        .W (NW0C)
    ) u_w0c (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en_i),
        .set     (w0c_set),
        .wr      (sts_wr_i),
        .wdata   (sts_wdata_i),
        .flags_o (w0c_flags)
    );

    // Buffer flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rxne_q <= 1'b0;
            txe_q  <= 1'b0;
        end else if (!en_i) begin
            rxne_q <= 1'b0;
            txe_q  <= 1'b0;
        end else begin
            if (set_i[F_RXNE])     rxne_q <= 1'b1;
            else if (dat_rd_i)     rxne_q <= 1'b0;
            if (set_i[F_TXE])      txe_q  <= 1'b1;
            else if (dat_wr_i)     txe_q  <= 1'b0;
        end
    end

    // Master-mode status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            master_q <= 1'b0;
        end else if (!en_i || set_i[F_ARB]) begin
            master_q <= 1'b0;
        end else if (set_i[F_START]) begin
            master_q <= 1'b1;
        end
    end

    always_comb begin
        flags_o          = '0;
        flags_o[NSEQ-1:0] = seq_flags;
        flags_o[F_WAKE]  = w0c_flags[0];
        flags_o[F_RXNE]  = rxne_q;
        flags_o[F_TXE]   = txe_q;
        flags_o[F_BUS]   = w0c_flags[1];
        flags_o[F_ARB]   = w0c_flags[2];
        flags_o[F_ACK]   = w0c_flags[3];
        flags_o[F_OVR]   = w0c_flags[4];
    end

    assign master_o = master_q;

    i2c_irq_merge #(
        .NEVT     (6),
        .NBUF     (2),
        .NERR     (4),
        .WAKE_IDX (F_WAKE)
    ) u_merge (
        .evt_flags (flags_o[F_WAKE:F_START]),
        .buf_flags (flags_o[F_TXE:F_RXNE]),
        .err_flags (flags_o[F_OVR:F_BUS]),
        .evt_ie    (evt_ie_i),
        .buf_ie    (buf_ie_i),
        .err_ie    (err_ie_i),
        .irq_evt_o (irq_evt_o),
        .irq_err_o (irq_err_o),
        .irq_o     (irq_o),
        .wake_o    (halt_wake_o)
    );

endmodule

// File: rtl/i2c_irq_flags_chk.sv
module i2c_irq_flags_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        en_i,
    input logic        evt_ie_i,
    input logic        err_ie_i,
    input logic [11:0] set_i,
    input logic        dat_rd_i,
    input logic        dat_wr_i,
    input logic [11:0] flags_o,
    input logic        master_o,
    input logic        irq_evt_o,
    input logic        irq_err_o,
    input logic        irq_o,
    input logic        halt_wake_o
);

    p_evt_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_ie_i |-> !irq_evt_o);

    p_err_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err_o == (err_ie_i && (flags_o[11:8] != 4'd0)));

    p_irq_or_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (irq_evt_o || irq_err_o));

    p_hdr_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(flags_o[2]) && $past(en_i)) |-> $past(dat_wr_i));

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && (set_i != 12'd0)) |=> ((flags_o & $past(set_i)) == $past(set_i)));

    p_rx_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(flags_o[6]) && $past(en_i)) |-> $past(dat_rd_i));

    p_tx_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(flags_o[7]) && $past(en_i)) |-> $past(dat_wr_i));

    p_arb_master_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && set_i[9]) |=> !master_o);

    p_disable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> ((flags_o == 12'd0) && !master_o));

    p_wake_r13: assert property (@(posedge clk) disable iff (!rst_n)
        halt_wake_o == (evt_ie_i && flags_o[5]));

endmodule

bind i2c_irq_flags i2c_irq_flags_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .evt_ie_i    (evt_ie_i),
    .err_ie_i    (err_ie_i),
    .set_i       (set_i),
    .dat_rd_i    (dat_rd_i),
    .dat_wr_i    (dat_wr_i),
    .flags_o     (flags_o),
    .master_o    (master_o),
    .irq_evt_o   (irq_evt_o),
    .irq_err_o   (irq_err_o),
    .irq_o       (irq_o),
    .halt_wake_o (halt_wake_o)
);

// File: tb/i2c_irq_flags_tb.sv
module i2c_irq_flags_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] A_SR = 5'b00001;
    localparam logic [4:0] A_DR = 5'b00010;
    localparam logic [4:0] A_DW = 5'b00100;
    localparam logic [4:0] A_CW = 5'b01000;
    localparam logic [4:0] A_SW = 5'b10000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_i = 1'b0, evt_ie_i = 1'b0, buf_ie_i = 1'b0, err_ie_i = 1'b0;
    logic [11:0] set_i = '0;
    logic        sts_rd_i = 1'b0, sts_wr_i = 1'b0, dat_rd_i = 1'b0, dat_wr_i = 1'b0, ctl_wr_i = 1'b0;
    logic [4:0]  sts_wdata_i = '0;
    logic [11:0] flags_o;
    logic        master_o, irq_evt_o, irq_err_o, irq_o, halt_wake_o;

    int total = 0;
    int fails = 0;

    logic [11:0] m_flags = '0;
    logic [4:0]  m_arm   = '0;
    logic        m_master = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_irq_flags dut_i (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .evt_ie_i(evt_ie_i), .buf_ie_i(buf_ie_i),
        .err_ie_i(err_ie_i), .set_i(set_i), .sts_rd_i(sts_rd_i), .sts_wr_i(sts_wr_i),
        .sts_wdata_i(sts_wdata_i), .dat_rd_i(dat_rd_i), .dat_wr_i(dat_wr_i),
        .ctl_wr_i(ctl_wr_i), .flags_o(flags_o), .master_o(master_o),
        .irq_evt_o(irq_evt_o), .irq_err_o(irq_err_o), .irq_o(irq_o),
        .halt_wake_o(halt_wake_o)
    );

    task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Second access per two-step flag (R5, R6)
    function automatic logic sec_hit(input int b, input logic dr, input logic dw, input logic cw);
        case (b)
            0: return dw;
            1: return dr;
            2: return dw;
            3: return cw;
            default: return dr | dw;
        endcase
    endfunction

    function automatic logic exp_evt();
        return evt_ie_i & ((|m_flags[5:0]) | (buf_ie_i & (|m_flags[7:6])));
    endfunction

    function automatic logic exp_err();
        return err_ie_i & (|m_flags[11:8]);
    endfunction

    task automatic model_step();
        logic [11:0] nf;
        logic [4:0]  na;
        logic        any_other;
        int          wmap [5];
        wmap[0] = 5; wmap[1] = 8; wmap[2] = 9; wmap[3] = 10; wmap[4] = 11;
        nf = m_flags;
        na = m_arm;
        any_other = sts_wr_i | dat_rd_i | dat_wr_i | ctl_wr_i;
        if (!en_i) begin
            nf = '0; na = '0; m_master = 1'b0;
        end else begin
            for (int b = 0; b < 5; b++) begin
                if (set_i[b]) nf[b] = 1'b1;
                else if (m_arm[b] && sec_hit(b, dat_rd_i, dat_wr_i, ctl_wr_i)) nf[b] = 1'b0;
                if (sts_rd_i) na[b] = m_flags[b];
                else if (any_other) na[b] = 1'b0;
            end
            for (int k = 0; k < 5; k++) begin
                if (set_i[wmap[k]]) nf[wmap[k]] = 1'b1;
                else if (sts_wr_i && !sts_wdata_i[k]) nf[wmap[k]] = 1'b0;
            end
            if (set_i[6]) nf[6] = 1'b1; else if (dat_rd_i) nf[6] = 1'b0;
            if (set_i[7]) nf[7] = 1'b1; else if (dat_wr_i) nf[7] = 1'b0;
            if (set_i[9]) m_master = 1'b0; else if (set_i[0]) m_master = 1'b1;
        end
        m_flags = nf;
        m_arm   = na;
    endtask

    task automatic compare_all();
        check("R6 two-step flags",    {7'd0, flags_o[4:0]}, {7'd0, m_flags[4:0]});
        check("R8 write-zero flags",  {7'd0, flags_o[11:8], flags_o[5]}, {7'd0, m_flags[11:8], m_flags[5]});
        check("R10 buffer flags",     {10'd0, flags_o[7:6]}, {10'd0, m_flags[7:6]});
        check("R11 master",           {11'd0, master_o}, {11'd0, m_master});
        check("R1 event irq",         {11'd0, irq_evt_o}, {11'd0, exp_evt()});
        check("R3 error irq",         {11'd0, irq_err_o}, {11'd0, exp_err()});
        check("R4 combined irq",      {11'd0, irq_o}, {11'd0, exp_evt() | exp_err()});
        check("R13 halt wake",        {11'd0, halt_wake_o}, {11'd0, evt_ie_i & m_flags[5]});
    endtask

    // Called at a falling edge; returns at the next falling edge
    task automatic tick(input logic [11:0] s, input logic [4:0] acc, input logic [4:0] wd);
        set_i = s;
        {sts_wr_i, ctl_wr_i, dat_wr_i, dat_rd_i, sts_rd_i} = acc;
        sts_wdata_i = wd;
        model_step();
        @(posedge clk);
        @(negedge clk);
        set_i = '0;
        {sts_wr_i, ctl_wr_i, dat_wr_i, dat_rd_i, sts_rd_i} = '0;
        compare_all();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        total++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [11:0] rs;
        logic [4:0]  ra;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R14 reset flags", flags_o, 12'd0);
        check("R14 reset outputs", {7'd0, master_o, irq_evt_o, irq_err_o, irq_o, halt_wake_o}, 12'd0);
        en_i = 1'b1; evt_ie_i = 1'b1; buf_ie_i = 1'b1; err_ie_i = 1'b1;

        // R5 / R7: 10-bit header order
        tick(12'h004, 5'd0, 5'h1f);
        tick(12'd0, A_SR, 5'h1f);
        tick(12'd0, A_DR, 5'h1f);
        tick(12'd0, A_DW, 5'h1f);
        check("R7 broken order keeps flag 2", {11'd0, flags_o[2]}, 12'd1);
        tick(12'd0, A_SR, 5'h1f);
        tick(12'd0, A_DW, 5'h1f);
        check("R5 status read then data write clears flag 2", {11'd0, flags_o[2]}, 12'd0);

        // R6: per-flag second accesses
        tick(12'h010, 5'd0, 5'h1f);
        tick(12'd0, A_SR, 5'h1f);
        tick(12'd0, A_DR, 5'h1f);
        check("R6 flag 4 cleared by data read", {11'd0, flags_o[4]}, 12'd0);
        tick(12'h001, 5'd0, 5'h1f);
        tick(12'd0, A_SR, 5'h1f);
        tick(12'd0, A_CW, 5'h1f);
        check("R6 flag 0 kept on control write", {11'd0, flags_o[0]}, 12'd1);
        tick(12'd0, A_SR, 5'h1f);
        tick(12'd0, A_DW, 5'h1f);
        check("R6 flag 0 cleared by data write", {11'd0, flags_o[0]}, 12'd0);

        // R9: same-cycle set and clear
        tick(12'h008, 5'd0, 5'h1f);
        tick(12'd0, A_SR, 5'h1f);
        tick(12'h008, A_CW, 5'h1f);
        check("R9 set beats two-step clear", {11'd0, flags_o[3]}, 12'd1);
        tick(12'd0, A_SR, 5'h1f);
        tick(12'd0, A_CW, 5'h1f);
        check("R6 flag 3 cleared by control write", {11'd0, flags_o[3]}, 12'd0);

        // R8 / R3: write-zero error flags
        tick(12'h500, 5'd0, 5'h1f);
        check("R3 error irq raised", {11'd0, irq_err_o}, 12'd1);
        tick(12'd0, A_SW, 5'b10111);
        check("R8 zero bit clears flag 10, one bit keeps flag 8", {10'd0, flags_o[10], flags_o[8]}, 12'b01);
        tick(12'h100, A_SW, 5'b00000);
        check("R9 set beats write-zero", {11'd0, flags_o[8]}, 12'd1);
        tick(12'd0, A_SW, 5'b00000);
        check("R8 flag 8 cleared", {11'd0, flags_o[8]}, 12'd0);

        // R2 / R10: buffer flags
        buf_ie_i = 1'b0;
        tick(12'h040, 5'd0, 5'h1f);
        check("R2 buffer flag masked", {11'd0, irq_evt_o}, 12'd0);
        buf_ie_i = 1'b1;
        #1;
        check("R2 buffer flag unmasked", {11'd0, irq_evt_o}, 12'd1);
        tick(12'h080, A_DR, 5'h1f);
        check("R10 data read clears flag 6 only", {10'd0, flags_o[7:6]}, 12'b10);
        tick(12'd0, A_DW, 5'h1f);
        check("R10 data write clears flag 7", {11'd0, flags_o[7]}, 12'd0);

        // R11: master mode
        tick(12'h001, 5'd0, 5'h1f);
        check("R11 start sets master", {11'd0, master_o}, 12'd1);
        tick(12'h201, 5'd0, 5'h1f);
        check("R11 arbitration loss wins", {11'd0, master_o}, 12'd0);

        // R13 / R1: wakeup
        tick(12'h020, 5'd0, 5'h1f);
        check("R13 wake raised", {11'd0, halt_wake_o}, 12'd1);
        evt_ie_i = 1'b0;
        #1;
        check("R1 event irq gated", {10'd0, irq_evt_o, halt_wake_o}, 12'd0);
        evt_ie_i = 1'b1;

        // R12: disable while armed
        tick(12'h004, 5'd0, 5'h1f);
        tick(12'd0, A_SR, 5'h1f);
        en_i = 1'b0;
        tick(12'h0ff, 5'd0, 5'h1f);
        check("R12 disabled flags clear", {flags_o[11:1], master_o}, 12'd0);
        en_i = 1'b1;
        tick(12'h004, 5'd0, 5'h1f);
        tick(12'd0, A_DW, 5'h1f);
        check("R12 arm dropped by disable", {11'd0, flags_o[2]}, 12'd1);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            rs = '0;
            for (int b = 0; b < 12; b++) if ($urandom_range(0, 9) == 0) rs[b] = 1'b1;
            ra = '0;
            begin
                int r;
                r = $urandom_range(0, 8);
                if (r < 5) ra = 5'd1 << r;
            end
            en_i     = ($urandom_range(0, 59) != 0);
            if ($urandom_range(0, 7) == 0) evt_ie_i = $urandom_range(0, 1) == 1;
            if ($urandom_range(0, 7) == 0) buf_ie_i = $urandom_range(0, 1) == 1;
            if ($urandom_range(0, 7) == 0) err_ie_i = $urandom_range(0, 1) == 1;
            tick(rs, ra, 5'($urandom_range(0, 31)));
        end

        finish_run();
    end

endmodule